// File: doc/BRIEF.md
# Single-Wire Byte Slot Engine

This block runs one byte-level transaction on a single-wire open-drain bus. A controller presents a 2-bit operation code, a data byte and a one-cycle start strobe. The engine then performs a bus reset with presence detection, an eight-bit write, an eight-bit read, or a strong drive-high request. It then returns a result byte with a one-cycle valid pulse.

The clock is meant to run at 1 MHz, so every timing parameter is a number of clock cycles equal to microseconds. The bus is reached through three pins: an output enable, a data-out value and the sampled line level. The bus is pulled low only by enabling the driver with a 0. Releasing the bus means disabling the driver and leaving the line to the external pull-up. Bits travel least significant first. Every bit slot, read or write, samples the line at the same point, so a write returns the byte it observed on the wire.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, and whenever no operation is active, `bus_oe` is 0 (bus released) and `op_valid` is 0, unless a strong drive-high is in force.
- R2: Operation code 2'b00 (bus reset) drives the bus low (`bus_oe`=1, `bus_dout`=0) for T_RST_LOW cycles, starting in the first cycle after the accepting edge. It then releases the bus for T_RST_REL cycles, and `op_valid` rises in the following cycle: 512+512+1 = 1025 cycles after acceptance with defaults.
- R3: The reset result is 1 in bit 0 if `bus_din` is low T_RST_SAMPLE cycles after the release begins, and 0 otherwise. All other result bits are 0.
- R4: Operation codes are 2'b00 bus reset, 2'b01 write byte, 2'b10 read byte and 2'b11 strong drive-high. The code and `op_wdata` are captured on the accepting edge.
- R5: A write slot drives the bus low for T_W0_LOW cycles (80) for a 0 bit and for T_W1_LOW cycles (8) for a 1 bit, and then releases it. Bit 0 of `op_wdata` is sent first.
- R6: A byte operation is eight back-to-back slots, each T_SLOT (90) cycles long. Slot k begins 1+90·k cycles after acceptance, and `op_valid` rises 8·90+1 = 721 cycles after acceptance.
- R7: A read slot drives the bus low for T_RD_LOW cycles (2), then releases it, and samples `bus_din` T_RD_SAMPLE cycles (8) after the slot begins. The first slot's bit lands in result bit 0.
- R8: A write returns as its result the line levels sampled in its slots, which equals the written byte on an undisturbed bus.
- R9: Operation code 2'b11 raises `op_valid` in the first cycle after acceptance with a zero result. From then on it holds `bus_oe`=1 and `bus_dout`=1 until the next start is accepted.
- R10: `op_valid` is high for exactly one cycle per operation.
- R11: A start strobe that arrives while an operation is active is ignored: the running operation keeps its timing and result, and no extra valid pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start strobe for one operation |
| op_cmd | input | 2 | Operation code |
| op_wdata | input | 8 | Byte to write |
| bus_oe | output | 1 | Bus driver enable |
| bus_dout | output | 1 | Level driven when enabled |
| bus_din | input | 1 | Sampled bus line level |
| op_result | output | 8 | Result byte, qualified by op_valid |
| op_valid | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase counter or state shows up at once as a bus-low pulse of the wrong width, or as a slot starting at the wrong offset. The bench measures each such pulse to the cycle, along with the total operation length. A wrong bit index or shift direction cannot be seen until valid, where it appears as a bit-reversed or misaligned result byte. Both a read of a slave-driven pattern and the write read-back expose it. A sampling point in the wrong place shows as a lost presence bit, or as read bits taken after the slave has let go.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [1:0] {
    CMD_RESET  = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_READ   = 2'b10,
    CMD_STRONG = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RST_LOW = 3'd1,
    S_RST_REL = 3'd2,
    S_SLOT    = 3'd3,
    S_DONE    = 3'd4
  } state_e;

endpackage

// File: rtl/owire_rst_sync.sv
module owire_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/owire_phase_timer.sv
module owire_phase_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/owire_bit_shifter.sv
module owire_bit_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  input  logic            smp_en,
  input  logic            smp_bit,
  input  logic            shift_en,
  output logic            tx_bit,
  output logic [BITS-1:0] data
);

  logic [BITS-1:0] data_q;
  logic [BITS-1:0] data_d;
  logic            smp_q;
  logic            smp_d;

  always_comb begin
    data_d = data_q;
    smp_d  = smp_q;
    if (load) begin
      data_d = load_val;
    end else if (shift_en) begin
      data_d = {smp_q, data_q[BITS-1:1]};
    end
    if (smp_en) begin
      smp_d = smp_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      smp_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      smp_q  <= smp_d;
    end
  end

  assign tx_bit = data_q[0];
  assign data   = data_q;

endmodule

// File: rtl/owire_slot_ctrl.sv
module owire_slot_ctrl
  import owire_pkg::*;
#(
  parameter int T_RST_LOW    = 512,
  parameter int T_RST_SAMPLE = 100,
  parameter int T_RST_REL    = 512,
  parameter int T_W0_LOW     = 80,
  parameter int T_W1_LOW     = 8,
  parameter int T_RD_LOW     = 2,
  parameter int T_SLOT       = 90,
  parameter int T_RD_SAMPLE  = 8,
  parameter int BITS         = 8,
  parameter int CNT_W        = 10,
  parameter int IDX_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cmd,
  input  logic [CNT_W-1:0] cnt,
  input  logic             tx_bit,
  input  logic             din,
  output logic             tmr_clr,
  output logic             tmr_en,
  output logic             sh_load,
  output logic             sh_smp,
  output logic             sh_shift,
  output logic             bus_low,
  output logic             strong_on,
  output logic             valid,
  output logic             presence,
  output logic [1:0]       op
);

  localparam logic [CNT_W-1:0] L_RL_END   = CNT_W'(T_RST_LOW - 1);
  localparam logic [CNT_W-1:0] L_RS_PT    = CNT_W'(T_RST_SAMPLE);
  localparam logic [CNT_W-1:0] L_RR_END   = CNT_W'(T_RST_REL - 1);
  localparam logic [CNT_W-1:0] L_W0       = CNT_W'(T_W0_LOW);
  localparam logic [CNT_W-1:0] L_W1       = CNT_W'(T_W1_LOW);
  localparam logic [CNT_W-1:0] L_RDL      = CNT_W'(T_RD_LOW);
  localparam logic [CNT_W-1:0] L_SMP      = CNT_W'(T_RD_SAMPLE);
  localparam logic [CNT_W-1:0] L_SLOT     = CNT_W'(T_SLOT);
  localparam logic [CNT_W-1:0] L_SLOT_END = CNT_W'(T_SLOT - 1);
  localparam logic [IDX_W-1:0] L_IDX_LAST = IDX_W'(BITS - 1);

  state_e           state_q, state_d;
  cmd_e             op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             strong_q, strong_d;
  logic             pres_q, pres_d;
  logic [CNT_W-1:0] low_len;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    idx_d    = idx_q;
    strong_d = strong_q;
    pres_d   = pres_q;
    tmr_clr  = 1'b0;
    tmr_en   = 1'b1;
    sh_load  = 1'b0;
    sh_smp   = 1'b0;
    sh_shift = 1'b0;
    valid    = 1'b0;
    case (state_q)
      S_IDLE: begin
        tmr_clr = 1'b1;
        if (start) begin
          op_d     = cmd_e'(cmd);
          idx_d    = '0;
          strong_d = 1'b0;
          pres_d   = 1'b0;
          sh_load  = 1'b1;
          case (cmd_e'(cmd))
            CMD_RESET:  state_d = S_RST_LOW;
            CMD_WRITE:  state_d = S_SLOT;
            CMD_READ:   state_d = S_SLOT;
            default: begin
              strong_d = 1'b1;
              state_d  = S_DONE;
            end
          endcase
        end
      end
      S_RST_LOW: begin
        if (cnt == L_RL_END) begin
          tmr_clr = 1'b1;
          state_d = S_RST_REL;
        end
      end
      S_RST_REL: begin
        if (cnt == L_RS_PT) begin
          pres_d = ~din;
        end
        if (cnt == L_RR_END) begin
          tmr_clr = 1'b1;
          state_d = S_DONE;
        end
      end
      S_SLOT: begin
        if (cnt == L_SMP) begin
          sh_smp = 1'b1;
        end
        if (cnt == L_SLOT_END) begin
          sh_shift = 1'b1;
          tmr_clr  = 1'b1;
          if (idx_q == L_IDX_LAST) begin
            state_d = S_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      S_DONE: begin
        valid   = 1'b1;
        tmr_clr = 1'b1;
        state_d = S_IDLE;
      end
      default: begin
        state_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      op_q     <= CMD_RESET;
      idx_q    <= '0;
      strong_q <= 1'b0;
      pres_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      idx_q    <= idx_d;
      strong_q <= strong_d;
      pres_q   <= pres_d;
    end
  end

  always_comb begin
    if (op_q == CMD_READ) begin
      low_len = L_RDL;
    end else if (tx_bit) begin
      low_len = L_W1;
    end else begin
      low_len = L_W0;
    end
  end

  assign bus_low   = (state_q == S_RST_LOW) || ((state_q == S_SLOT) && (cnt < low_len));
  assign strong_on = strong_q;
  assign presence  = pres_q;
  assign op        = op_q;

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SLOT) |-> (cnt < L_SLOT)); // R6

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_SLOT) |=> ((state_q != S_SLOT) || (idx_q == '0) || $stable(idx_q) || (idx_q == $past(idx_q) + 1'b1))); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != S_IDLE) && start) |=> $stable(op_q)); // R11

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R10

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owire_pkg::*;
#(
  parameter int T_RST_LOW    = 512,
  parameter int T_RST_SAMPLE = 100,
  parameter int T_RST_REL    = 512,
  parameter int T_W0_LOW     = 80,
  parameter int T_W1_LOW     = 8,
  parameter int T_RD_LOW     = 2,
  parameter int T_SLOT       = 90,
  parameter int T_RD_SAMPLE  = 8,
  parameter int BITS         = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_start,
  input  logic [1:0]      op_cmd,
  input  logic [BITS-1:0] op_wdata,
  output logic            bus_oe,
  output logic            bus_dout,
  input  logic            bus_din,
  output logic [BITS-1:0] op_result,
  output logic            op_valid
);

  localparam int MAX_RST = (T_RST_LOW > T_RST_REL) ? T_RST_LOW : T_RST_REL;
  localparam int MAX_T   = (MAX_RST > T_SLOT) ? MAX_RST : T_SLOT;
  localparam int CNT_W   = $clog2(MAX_T + 1);
  localparam int IDX_W   = (BITS > 1) ? $clog2(BITS) : 1;

  logic             srst_n;
  logic [CNT_W-1:0] cnt;
  logic             tmr_clr, tmr_en;
  logic             sh_load, sh_smp, sh_shift;
  logic             tx_bit;
  logic [BITS-1:0]  sh_data;
  logic             bus_low, strong_on, presence;
  logic [1:0]       op;

  owire_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  owire_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .cnt   (cnt)
  );

  owire_bit_shifter #(.BITS(BITS)) u_shift (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (sh_load),
    .load_val (op_wdata),
    .smp_en   (sh_smp),
    .smp_bit  (bus_din),
    .shift_en (sh_shift),
    .tx_bit   (tx_bit),
    .data     (sh_data)
  );

  owire_slot_ctrl #(
    .T_RST_LOW    (T_RST_LOW),
    .T_RST_SAMPLE (T_RST_SAMPLE),
    .T_RST_REL    (T_RST_REL),
    .T_W0_LOW     (T_W0_LOW),
    .T_W1_LOW     (T_W1_LOW),
    .T_RD_LOW     (T_RD_LOW),
    .T_SLOT       (T_SLOT),
    .T_RD_SAMPLE  (T_RD_SAMPLE),
    .BITS         (BITS),
    .CNT_W        (CNT_W),
    .IDX_W        (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (op_start),
    .cmd       (op_cmd),
    .cnt       (cnt),
    .tx_bit    (tx_bit),
    .din       (bus_din),
    .tmr_clr   (tmr_clr),
    .tmr_en    (tmr_en),
    .sh_load   (sh_load),
    .sh_smp    (sh_smp),
    .sh_shift  (sh_shift),
    .bus_low   (bus_low),
    .strong_on (strong_on),
    .valid     (op_valid),
    .presence  (presence),
    .op        (op)
  );

  assign bus_oe   = bus_low | strong_on;
  assign bus_dout = strong_on & ~bus_low;

  always_comb begin
    case (cmd_e'(op))
      CMD_RESET:  op_result = {{(BITS-1){1'b0}}, presence};
      CMD_STRONG: op_result = '0;
      default:    op_result = sh_data;
    endcase
  end

  AST_STRONG_PINS: assert property (@(posedge clk) disable iff (!srst_n)
    strong_on |-> (bus_oe && bus_dout)); // R9

  AST_RELEASED_AT_VALID: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && !strong_on) |-> !bus_oe); // R2

  AST_LOW_ENDS_CLEAN: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(bus_low) |-> !op_valid); // R5

endmodule

// File: tb/tb_owire_slot_engine.sv
`timescale 1ns/1ps
module tb_owire_slot_engine;

  logic       clk;
  logic       rst_n;
  logic       op_start;
  logic [1:0] op_cmd;
  logic [7:0] op_wdata;
  logic       bus_oe, bus_dout, bus_din;
  logic [7:0] op_result;
  logic       op_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  int lw [0:15];
  int ls [0:15];
  int nlow;
  int dur;
  int extra_valid;
  logic [7:0] res;

  int         slave_mode = 0;
  logic [7:0] slave_byte = 8'h00;
  int         slave_idx = 0;
  int         hold = 0;
  int         pdel = 0;
  logic       slave_low = 1'b0;
  logic       low_prev = 1'b0;

  owire_slot_engine dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .op_cmd    (op_cmd),
    .op_wdata  (op_wdata),
    .bus_oe    (bus_oe),
    .bus_dout  (bus_dout),
    .bus_din   (bus_din),
    .op_result (op_result),
    .op_valid  (op_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign bus_din = bus_oe ? bus_dout : ~slave_low;

  // slave device model, acting on the falling clock edge
  always @(negedge clk) begin
    logic drv_low;
    drv_low = bus_oe && !bus_dout;
    if (slave_mode == 2 && drv_low && !low_prev) begin
      if (!slave_byte[slave_idx % 8]) hold = 30;
      slave_idx++;
    end
    if (slave_mode == 1 && !drv_low && low_prev) begin
      pdel = 20;
    end else if (pdel > 0) begin
      pdel--;
      if (pdel == 0) hold = 150;
    end
    slave_low = (hold > 0);
    if (hold > 0) hold--;
    low_prev = drv_low;
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc_total);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // issue one operation and record driven-low pulses until valid
  task automatic run_op(input logic [1:0] c, input logic [7:0] d, input int inject_at);
    bit prev;
    int cyc;
    prev = 0; nlow = 0; dur = -1; extra_valid = 0; res = 8'h00;
    for (int i = 0; i < 16; i++) begin lw[i] = 0; ls[i] = 0; end
    @(negedge clk);
    op_cmd = c; op_wdata = d; op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    op_wdata = 8'h00;
    cyc = 1;
    while (cyc < 3000) begin
      if (cyc == inject_at) begin op_start = 1'b1; op_cmd = 2'b10; end
      else op_start = 1'b0;
      if (bus_oe && !bus_dout) begin
        if (!prev && nlow < 16) begin ls[nlow] = cyc; nlow++; end
        if (nlow > 0 && nlow <= 16) lw[nlow-1]++;
        prev = 1;
      end else begin
        prev = 0;
      end
      if (op_valid) begin res = op_result; dur = cyc; break; end
      cyc++;
      @(negedge clk);
    end
    op_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (op_valid) extra_valid++;
    end
  endtask

  task automatic t_reset_state;
    check("R1 oe after reset", bus_oe, 0);
    check("R1 valid after reset", op_valid, 0);
  endtask

  task automatic t_reset_present;
    slave_mode = 1;
    run_op(2'b00, 8'h00, -1);
    slave_mode = 0;
    check("R2 low pulse count", nlow, 1);
    check("R2 low width", lw[0], 512);
    check("R2 valid offset", dur, 1025);
    check("R3 presence result", res, 8'h01);
    check("R10 single valid", extra_valid, 0);
    check("R1 released after op", bus_oe, 0);
  endtask

  task automatic t_reset_absent;
    slave_mode = 0;
    run_op(2'b00, 8'hFF, -1);
    check("R3 no presence result", res, 8'h00);
    check("R4 reset code dur", dur, 1025);
  endtask

  task automatic t_write(input logic [7:0] b);
    slave_mode = 0;
    run_op(2'b01, b, -1);
    check("R6 slot count", nlow, 8);
    for (int k = 0; k < 8; k++) begin
      check("R5 write low width", lw[k], b[k] ? 8 : 80);
      check("R6 slot start", ls[k], 1 + 90 * k);
    end
    check("R6 valid offset", dur, 721);
    check("R8 readback", res, b);
    check("R10 single valid", extra_valid, 0);
  endtask

  task automatic t_read(input logic [7:0] b);
    slave_mode = 2; slave_byte = b; slave_idx = 0;
    run_op(2'b10, 8'hA5, -1);
    slave_mode = 0;
    check("R7 slots seen by slave", slave_idx, 8);
    for (int k = 0; k < 8; k++) check("R7 read low width", lw[k], 2);
    check("R7 read result", res, b);
    check("R6 read valid offset", dur, 721);
  endtask

  task automatic t_strong;
    run_op(2'b11, 8'h77, -1);
    check("R9 valid offset", dur, 1);
    check("R9 result", res, 8'h00);
    check("R10 single valid", extra_valid, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9 strong oe", bus_oe, 1);
      check("R9 strong dout", bus_dout, 1);
    end
    run_op(2'b00, 8'h00, -1);
    check("R9 strong cleared by next op", lw[0], 512);
    check("R9 released after", bus_oe, 0);
  endtask

  task automatic t_ignore;
    run_op(2'b01, 8'h96, 300);
    check("R11 duration kept", dur, 721);
    check("R11 result kept", res, 8'h96);
    check("R11 no extra valid", extra_valid, 0);
    check("R11 slot count", nlow, 8);
  endtask

  initial begin
    op_start = 1'b0; op_cmd = 2'b00; op_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_reset_present();
    t_reset_absent();
    t_write(8'hA5);
    t_write(8'h0F);
    t_read(8'h3C);
    t_read(8'hC1);
    t_strong();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule